// File: doc/BRIEF.md
# Single-Bit Shift and Rotate Unit with Carry

This block moves a data word by exactly one bit position and computes the condition flags for the result. It supports eight operations: logical and arithmetic shifts in both directions, plain rotates in both directions, and rotates that pass through the carry flag. In the carry rotates, the carry flag acts as one extra bit of the word. Every operation writes a new carry flag. The overflow flag is always written. The zero and sign flags are written only by the shift operations. The plain and carry rotates leave zero and sign at their earlier values.

The caller presents an operand, a 3-bit operation code and the current carry flag, and raises `in_valid` for one cycle. The result and all four flags appear on registered outputs one cycle later. `out_valid` is high for that cycle. While `in_valid` is low, the result and flag outputs keep their last values. The operand width is a parameter (`WIDTH`, default 16, minimum 2).

Top module: `shrot_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `out_result`, `out_cf`, `out_zf`, `out_sf` and `out_of` are all 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, the result and flag outputs keep their values on the next clock.
- R3: For op codes 000 and 001, the result is the operand shifted left by one with 0 entering bit 0. `out_cf` takes the operand's MSB.
- R4: For op code 010, the result is the operand shifted right by one with 0 entering the MSB. `out_cf` takes the operand's bit 0.
- R5: For op code 011, the result is the operand shifted right by one with the old MSB kept in the MSB. `out_cf` takes the operand's bit 0. `out_of` is 0.
- R6: For op code 100, the operand's MSB moves to both bit 0 and `out_cf`. For op code 101, the operand's bit 0 moves to both the MSB and `out_cf`.
- R7: For op code 110, `in_carry` enters bit 0 and the operand's MSB goes to `out_cf`. For op code 111, `in_carry` enters the MSB and the operand's bit 0 goes to `out_cf`.
- R8: For op codes 000 to 011, `out_zf` is 1 exactly when the result is all zeros, and `out_sf` equals the result's MSB.
- R9: For op codes 100 to 111, `out_zf` and `out_sf` keep their previous values.
- R10: For op codes 000, 001, 100 and 110, `out_of` is the XOR of the result's two top bits. For op codes 010, 101 and 111, `out_of` is the XOR of the operand's two top bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand, op code and carry are valid this cycle |
| in_data | input | WIDTH | Operand word |
| in_op | input | 3 | Operation code |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered result is new this cycle |
| out_result | output | WIDTH | Shifted or rotated word |
| out_cf | output | 1 | Updated carry flag |
| out_zf | output | 1 | Zero flag |
| out_sf | output | 1 | Sign flag |
| out_of | output | 1 | Overflow flag |

## Verification
There is one register stage between the inputs and the outputs, so every output belongs to the input accepted at the previous rising edge. The bench drives inputs on falling edges and samples outputs on the next falling edge, which falls after the single capturing edge. Its model keeps its own copy of the zero and sign flags, so it can predict that the rotates leave them unchanged. Idle cycles with changing inputs are checked the same way, one edge after they are driven, to confirm that the outputs hold.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'b000,
    OP_SAL = 3'b001,
    OP_SHR = 3'b010,
    OP_SAR = 3'b011,
    OP_ROL = 3'b100,
    OP_ROR = 3'b101,
    OP_RCL = 3'b110,
    OP_RCR = 3'b111
  } shrot_op_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
  } shrot_flags_t;
endpackage

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] d,
  input  shrot_op_e        op,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  localparam int MSB = WIDTH - 1;

  // Left movers discard the MSB, right movers discard bit 0.
  logic [WIDTH-1:0] left_body;
  logic [WIDTH-1:0] right_body;
  assign left_body  = {d[MSB-1:0], 1'b0};
  assign right_body = {1'b0, d[MSB:1]};

  always_comb begin
    res  = left_body;
    cout = d[MSB];
    unique case (op)
      OP_SHL, OP_SAL: begin
        res  = left_body;
        cout = d[MSB];
      end
      OP_SHR: begin
        res  = right_body;
        cout = d[0];
      end
      OP_SAR: begin
        res  = right_body | {d[MSB], {MSB{1'b0}}};
        cout = d[0];
      end
      OP_ROL: begin
        res  = left_body | {{MSB{1'b0}}, d[MSB]};
        cout = d[MSB];
      end
      OP_ROR: begin
        res  = right_body | {d[0], {MSB{1'b0}}};
        cout = d[0];
      end
      OP_RCL: begin
        res  = left_body | {{MSB{1'b0}}, cin};
        cout = d[MSB];
      end
      OP_RCR: begin
        res  = right_body | {cin, {MSB{1'b0}}};
        cout = d[0];
      end
      default: begin
        res  = left_body;
        cout = d[MSB];
      end
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] res,
  input  shrot_op_e        op,
  output logic             is_rotate,
  output logic             zf,
  output logic             sf,
  output logic             of
);
  localparam int MSB = WIDTH - 1;

  logic left_of;
  logic right_of;
  assign left_of  = res[MSB] ^ res[MSB-1];
  assign right_of = d[MSB] ^ d[MSB-1];

  // Op code bit 2 separates the rotates from the shifts.
  assign is_rotate = op[2];
  assign zf        = (res == '0);
  assign sf        = res[MSB];

  always_comb begin
    unique case (op)
      OP_SHL, OP_SAL, OP_ROL, OP_RCL: of = left_of;
      OP_SAR:                         of = 1'b0;
      default:                        of = right_of;
    endcase
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic [2:0]       in_op,
  input  logic             in_carry,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_result,
  output logic             out_cf,
  output logic             out_zf,
  output logic             out_sf,
  output logic             out_of
);
  localparam int MSB = WIDTH - 1;

  shrot_op_e        op_e;
  logic [WIDTH-1:0] nxt_res;
  logic             nxt_cf;
  logic             nxt_zf;
  logic             nxt_sf;
  logic             nxt_of;
  logic             rot;
  shrot_flags_t     flg_q;

  assign op_e = shrot_op_e'(in_op);

  shrot_core #(.WIDTH(WIDTH)) core_i (
    .d    (in_data),
    .op   (op_e),
    .cin  (in_carry),
    .res  (nxt_res),
    .cout (nxt_cf)
  );

  shrot_flags #(.WIDTH(WIDTH)) flags_i (
    .d         (in_data),
    .res       (nxt_res),
    .op        (op_e),
    .is_rotate (rot),
    .zf        (nxt_zf),
    .sf        (nxt_sf),
    .of        (nxt_of)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      flg_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nxt_res;
        flg_q.cf   <= nxt_cf;
        flg_q.of   <= nxt_of;
        if (!rot) begin
          flg_q.zf <= nxt_zf;
          flg_q.sf <= nxt_sf;
        end
      end
    end
  end

  assign out_cf = flg_q.cf;
  assign out_zf = flg_q.zf;
  assign out_sf = flg_q.sf;
  assign out_of = flg_q.of;

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_cf)
                   && $stable(out_of)));
  a_r3_left_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[2:1] == 2'b00) |=> (out_cf == $past(in_data[MSB])
                                           && !out_result[0]));
  a_r5_sar_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'b011) |=> !out_of);
  a_r7_rcl_carry_in: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'b110) |=> (out_result[0] == $past(in_carry)));
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_op[2]) |=> (out_zf == (out_result == '0)));
  a_r9_rotate_keeps_zs: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[2]) |=> ($stable(out_zf) && $stable(out_sf)));
endmodule

// File: tb/shrot_unit_tb_top.sv
module shrot_unit_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [2:0]   in_op = '0;
  logic         in_carry = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_result;
  logic         out_cf, out_zf, out_sf, out_of;

  int checks = 0;
  int failures = 0;
  logic m_zf = 1'b0;
  logic m_sf = 1'b0;
  logic [W-1:0] m_res = '0;
  logic m_cf = 1'b0;
  logic m_of = 1'b0;

  always #4 clk = ~clk;

  shrot_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_op(in_op), .in_carry(in_carry), .out_valid(out_valid),
    .out_result(out_result), .out_cf(out_cf), .out_zf(out_zf),
    .out_sf(out_sf), .out_of(out_of)
  );

  task automatic chk(input string req, input logic [W-1:0] got,
                     input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Reference model built from the requirements.
  task automatic model(input logic [W-1:0] d, input logic [2:0] op,
                       input logic cin);
    logic [W-1:0] r;
    logic c;
    case (op)
      3'd0, 3'd1: begin r = d << 1; c = d[W-1]; end
      3'd2:       begin r = d >> 1; c = d[0]; end
      3'd3:       begin r = {d[W-1], d[W-1:1]}; c = d[0]; end
      3'd4:       begin r = {d[W-2:0], d[W-1]}; c = d[W-1]; end
      3'd5:       begin r = {d[0], d[W-1:1]}; c = d[0]; end
      3'd6:       begin r = {d[W-2:0], cin}; c = d[W-1]; end
      default:    begin r = {cin, d[W-1:1]}; c = d[0]; end
    endcase
    m_res = r;
    m_cf  = c;
    if (op == 3'd3)                                   m_of = 1'b0;
    else if (op == 3'd0 || op == 3'd1 || op == 3'd4 || op == 3'd6)
                                                      m_of = r[W-1] ^ r[W-2];
    else                                              m_of = d[W-1] ^ d[W-2];
    if (!op[2]) begin
      m_zf = (r == '0);
      m_sf = r[W-1];
    end
  endtask

  task automatic run_op(input logic [W-1:0] d, input logic [2:0] op,
                        input logic cin);
    in_valid = 1'b1; in_data = d; in_op = op; in_carry = cin;
    model(d, op, cin);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 valid", {15'b0, out_valid}, 16'd1);
    case (op)
      3'd0, 3'd1: chk("R3 shl result", out_result, m_res);
      3'd2:       chk("R4 shr result", out_result, m_res);
      3'd3:       chk("R5 sar result", out_result, m_res);
      3'd4, 3'd5: chk("R6 rotate result", out_result, m_res);
      default:    chk("R7 rcx result", out_result, m_res);
    endcase
    chk(op[2] ? (op[1] ? "R7 carry" : "R6 carry") : "R3 R4 R5 carry",
        {15'b0, out_cf}, {15'b0, m_cf});
    chk(op[2] ? "R9 zf kept" : "R8 zf", {15'b0, out_zf}, {15'b0, m_zf});
    chk(op[2] ? "R9 sf kept" : "R8 sf", {15'b0, out_sf}, {15'b0, m_sf});
    chk(op == 3'd3 ? "R5 of" : "R10 of", {15'b0, out_of}, {15'b0, m_of});
  endtask

  task automatic idle(input logic [W-1:0] d);
    in_valid = 1'b0; in_data = d; in_op = 3'd0; in_carry = ~in_carry;
    @(negedge clk);
    chk("R2 idle valid", {15'b0, out_valid}, 16'd0);
    chk("R2 idle hold", out_result, m_res);
    chk("R2 idle cf", {15'b0, out_cf}, {15'b0, m_cf});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset valid", {15'b0, out_valid}, 16'd0);
    chk("R1 reset result", out_result, '0);
    chk("R1 reset flags", {12'b0, out_cf, out_zf, out_sf, out_of}, 16'd0);
    // Directed corner cases.
    run_op(16'h8000, 3'd0, 1'b0);  // R3 to zero, carry out
    run_op(16'h4000, 3'd1, 1'b0);  // R10 overflow on sign change
    run_op(16'h0001, 3'd2, 1'b0);  // R4 to zero
    run_op(16'h8001, 3'd3, 1'b0);  // R5 sign kept
    run_op(16'h8000, 3'd4, 1'b0);  // R6 wraps, R9 zf kept
    run_op(16'h0001, 3'd5, 1'b0);  // R6
    run_op(16'h0000, 3'd6, 1'b1);  // R7 carry enters
    run_op(16'h0001, 3'd7, 1'b1);  // R7 carry enters MSB
    run_op(16'h7fff, 3'd3, 1'b1);
    idle(16'hdead);
    idle(16'hbeef);
    for (int i = 0; i < 400; i++) begin
      run_op(16'($urandom), 3'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) idle(16'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule